// File: doc/BRIEF.md
# Block Cipher Subkey Stream Generator

This block turns a 128-bit cipher key into the 52 sixteen-bit subkeys that an eight-round cipher of the IDEA family uses for encryption. The subkeys leave one per clock on a streaming output. Each one carries a round number and a position inside that round, so a round datapath, or an engine that fills a subkey store, can take them as they arrive and needs no counters of its own.

The schedule cuts the key register into 16-bit words, taking the most significant word first. Once eight words have left, the whole register rotates left by 25 bits and is cut again. The run stops after 52 words, so only four words of the seventh rotated slice are used. Rounds 1 to 8 each take six subkeys, and round 9, the output transformation, takes the last four.

A one-cycle start pulse latches the key. Emission begins in the next cycle and runs without gaps until the 52nd subkey, which is marked by done. Start pulses that arrive during a run are ignored.

Top module: `subkey_stream`

## Requirements
- R1: The first eight subkeys of a run are the key's eight 16-bit words, starting with bits 127:112 and ending with bits 15:0.
- R2: After every eighth subkey, the internal 128-bit value rotates circularly left by 25 bits. The next eight subkeys are its words, most significant word first. For key 0x0001_0002_0003_0004_0005_0006_0007_0008, the ninth subkey is 0x0400.
- R3: A start pulse taken while idle makes valid_o high in the very next cycle. Valid then stays high for exactly 52 consecutive cycles.
- R4: done_o is high only in the cycle that carries the 52nd subkey. valid_o is low in the cycle after it.
- R5: round_o/slot_o step through 1/0 to 1/5, then 2/0, and so on up to 8/5, then 9/0 to 9/3. Subkey n (counting from 0) is in round n/6+1, slot n mod 6.
- R6: A start pulse while a run is in progress has no effect. The running sequence, including its key, continues unchanged and no second run follows.
- R7: With rst_n low at a clock edge, valid_o and done_o are low after that edge and the block is idle. An interrupted run is abandoned.
- R8: valid_o stays low while idle, until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch pulse; key_i sampled with it |
| key_i | input | 128 | Cipher key |
| subkey_o | output | 16 | Current subkey |
| valid_o | output | 1 | subkey_o, round_o, slot_o are meaningful |
| round_o | output | 4 | Round number, 1 to 9 |
| slot_o | output | 3 | Position in round, 0 to 5 |
| done_o | output | 1 | High with the last subkey |

## Verification
The bench builds the block with its default parameters: a 128-bit key, 16-bit words, a rotation of 25, 52 subkeys and six per round. These values bring about the partial seventh slice and the short ninth round, so every rotation boundary is reached, including one that falls in the middle of a round. The runs use a counting key, a random key and a key with all bits set, and they include a start pulse in the middle of a run and a reset that cuts a run short.

// File: rtl/subkey_pkg.sv
// Package: default schedule geometry shared by the generator and its parts.
// Assumes a key that is a whole number of words.
package subkey_pkg;
    localparam int KEY_W_DEF     = 128;
    localparam int WORD_W_DEF    = 16;
    localparam int ROT_DEF       = 25;
    localparam int NUM_SUB_DEF   = 52;
    localparam int PER_ROUND_DEF = 6;

    // Integer ceiling division used for round counts.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/key_rotator.sv
// key_rotator: holds the working key. A load takes a new key and a step
// rotates the value left by ROT bits. Assumes 0 < ROT < KEY_W.
module key_rotator #(
    parameter int KEY_W = subkey_pkg::KEY_W_DEF,
    parameter int ROT   = subkey_pkg::ROT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] load_val,
    input  logic             step,
    output logic [KEY_W-1:0] key_q
);
    logic [KEY_W-1:0] rotated;

    // Circular left rotation of the held value.
    always_comb rotated = {key_q[KEY_W-ROT-1:0], key_q[KEY_W-1:KEY_W-ROT]};

    // Register: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n)    key_q <= '0;
        else if (load) key_q <= load_val;
        else if (step) key_q <= rotated;
    end
endmodule

// File: rtl/word_pick.sv
// word_pick: selects one word of the key, with index 0 giving the most
// significant word. Assumes KEY_W is a multiple of WORD_W.
module word_pick #(
    parameter int KEY_W  = subkey_pkg::KEY_W_DEF,
    parameter int WORD_W = subkey_pkg::WORD_W_DEF,
    localparam int NWORD = KEY_W / WORD_W,
    localparam int IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic [KEY_W-1:0]  key_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] words [NWORD];

    for (genvar g = 0; g < NWORD; g++) begin : g_split
        assign words[g] = key_i[KEY_W-1-g*WORD_W -: WORD_W];
    end

    // Index into the split words.
    always_comb word_o = words[idx_i];
endmodule

// File: rtl/seq_counter.sv
// seq_counter: tracks the word position in the slice, the total subkey
// count and the round and slot numbers. A launch clears them and every busy
// cycle advances them. Assumes launch and busy never occur together.
module seq_counter #(
    parameter int KEY_W     = subkey_pkg::KEY_W_DEF,
    parameter int WORD_W    = subkey_pkg::WORD_W_DEF,
    parameter int NUM_SUB   = subkey_pkg::NUM_SUB_DEF,
    parameter int PER_ROUND = subkey_pkg::PER_ROUND_DEF,
    localparam int NWORD    = KEY_W / WORD_W,
    localparam int IDX_W    = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int CNT_W    = $clog2(NUM_SUB),
    localparam int NROUND   = subkey_pkg::ceil_div(NUM_SUB, PER_ROUND),
    localparam int RND_W    = $clog2(NROUND + 1),
    localparam int SLOT_W   = (PER_ROUND > 1) ? $clog2(PER_ROUND) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              busy,
    output logic [IDX_W-1:0]  word_idx,
    output logic              slice_end,
    output logic              last_sub,
    output logic [RND_W-1:0]  round_q,
    output logic [SLOT_W-1:0] slot_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             round_end;

    // End-of-slice, end-of-run and end-of-round flags.
    always_comb begin
        slice_end = (word_idx == IDX_W'(NWORD - 1));
        last_sub  = (cnt_q == CNT_W'(NUM_SUB - 1));
        round_end = (slot_q == SLOT_W'(PER_ROUND - 1));
    end

    // Word-in-slice and total subkey counters.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            word_idx <= '0;
            cnt_q    <= '0;
        end else if (busy) begin
            word_idx <= slice_end ? '0 : word_idx + 1'b1;
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // Round and slot counters; rounds are numbered from 1.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            round_q <= RND_W'(1);
            slot_q  <= '0;
        end else if (busy) begin
            if (round_end) begin
                slot_q  <= '0;
                round_q <= round_q + 1'b1;
            end else begin
                slot_q  <= slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/subkey_stream.sv
// subkey_stream: expands a key into the encryption subkey stream, one
// subkey per cycle, from the cycle after an accepted start up to done.
// Assumes start_i is sampled only while idle; key_i matters only with start.
module subkey_stream #(
    parameter int KEY_W     = subkey_pkg::KEY_W_DEF,
    parameter int WORD_W    = subkey_pkg::WORD_W_DEF,
    parameter int ROT       = subkey_pkg::ROT_DEF,
    parameter int NUM_SUB   = subkey_pkg::NUM_SUB_DEF,
    parameter int PER_ROUND = subkey_pkg::PER_ROUND_DEF,
    localparam int NWORD    = KEY_W / WORD_W,
    localparam int IDX_W    = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int NROUND   = subkey_pkg::ceil_div(NUM_SUB, PER_ROUND),
    localparam int RND_W    = $clog2(NROUND + 1),
    localparam int SLOT_W   = (PER_ROUND > 1) ? $clog2(PER_ROUND) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [KEY_W-1:0]  key_i,
    output logic [WORD_W-1:0] subkey_o,
    output logic              valid_o,
    output logic [RND_W-1:0]  round_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              done_o
);
    logic             busy_q;
    logic             launch;
    logic             slice_end;
    logic             last_sub;
    logic [IDX_W-1:0] word_idx;
    logic [KEY_W-1:0] key_q;

    // A start is taken only while idle.
    always_comb launch = start_i && !busy_q;

    // Run flag: set by launch, cleared after the last subkey.
    always_ff @(posedge clk) begin
        if (!rst_n)                   busy_q <= 1'b0;
        else if (launch)              busy_q <= 1'b1;
        else if (busy_q && last_sub)  busy_q <= 1'b0;
    end

    key_rotator #(.KEY_W(KEY_W), .ROT(ROT)) u_rot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (key_i),
        .step     (busy_q && slice_end),
        .key_q    (key_q)
    );

    seq_counter #(
        .KEY_W(KEY_W), .WORD_W(WORD_W),
        .NUM_SUB(NUM_SUB), .PER_ROUND(PER_ROUND)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .busy      (busy_q),
        .word_idx  (word_idx),
        .slice_end (slice_end),
        .last_sub  (last_sub),
        .round_q   (round_o),
        .slot_q    (slot_o)
    );

    word_pick #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_pick (
        .key_i  (key_q),
        .idx_i  (word_idx),
        .word_o (subkey_o)
    );

    // Stream qualifiers.
    always_comb begin
        valid_o = busy_q;
        done_o  = busy_q && last_sub;
    end
endmodule

// File: rtl/subkey_stream_chk.sv
// subkey_stream_chk: protocol properties of the subkey stream, checked
// at the ports of subkey_stream and attached with bind.
module subkey_stream_chk #(
    parameter int RND_W  = 4,
    parameter int SLOT_W = 3,
    parameter int NROUND = 9,
    parameter int PER_ROUND = 6,
    parameter int LAST_SLOT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              valid_o,
    input logic              done_o,
    input logic [RND_W-1:0]  round_o,
    input logic [SLOT_W-1:0] slot_o
);
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && round_o == RND_W'(1) && slot_o == '0));

    p_gapless_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o) |=> valid_o);

    p_done_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

    p_done_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o);

    p_done_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (round_o == RND_W'(NROUND) && slot_o == SLOT_W'(LAST_SLOT)));

    p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o && slot_o != SLOT_W'(PER_ROUND - 1))
        |=> (slot_o == $past(slot_o) + 1'b1 && round_o == $past(round_o)));

    p_round_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o && slot_o == SLOT_W'(PER_ROUND - 1))
        |=> (slot_o == '0 && round_o == $past(round_o) + 1'b1));

    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !done_o));
endmodule

bind subkey_stream subkey_stream_chk #(
    .RND_W(RND_W), .SLOT_W(SLOT_W), .NROUND(NROUND),
    .PER_ROUND(PER_ROUND), .LAST_SLOT((NUM_SUB - 1) % PER_ROUND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_o(valid_o),
    .done_o(done_o), .round_o(round_o), .slot_o(slot_o)
);

// File: tb/tb_subkey_stream.sv
// Scoreboard bench: a driver task queues the expected stream from a
// rotation model and a monitor pops and compares at each negative edge.
module tb_subkey_stream;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB = 52;

    typedef struct packed {
        logic [15:0] sk;
        logic [3:0]  rnd;
        logic [2:0]  slot;
        logic        done;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [15:0]  subkey_o;
    logic         valid_o;
    logic [3:0]   round_o;
    logic [2:0]   slot_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int seen = 0;
    exp_t q[$];
    logic [15:0] obs [NSUB];

    always #(CLK_PERIOD/2) clk = ~clk;

    subkey_stream dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .subkey_o(subkey_o), .valid_o(valid_o), .round_o(round_o),
        .slot_o(slot_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each valid output against the queue head.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "unexpected valid", 64'(subkey_o), 64'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(subkey_o == e.sk, "R1/R2", "subkey", 64'(subkey_o), 64'(e.sk));
                check(round_o == e.rnd && slot_o == e.slot, "R5", "round/slot",
                      64'({round_o, slot_o}), 64'({e.rnd, e.slot}));
                check(done_o == e.done, "R4", "done", 64'(done_o), 64'(e.done));
                if (seen < NSUB) obs[seen] = subkey_o;
                seen++;
            end
        end
    end

    // Driver: builds the expected stream, then pulses start.
    task automatic run_key(input logic [127:0] key, input bit stray_start);
        logic [127:0] m;
        m = key;
        seen = 0;
        for (int i = 0; i < NSUB; i++) begin
            exp_t e;
            e.sk   = m[127 - 16*(i % 8) -: 16];
            e.rnd  = 4'(i / 6 + 1);
            e.slot = 3'(i % 6);
            e.done = (i == NSUB - 1);
            q.push_back(e);
            if (i % 8 == 7) m = {m[102:0], m[127:103]};
        end
        @(negedge clk);
        start_i = 1'b1;
        key_i   = key;
        @(negedge clk);
        start_i = 1'b0;
        check(valid_o == 1'b1, "R3", "valid after start", 64'(valid_o), 64'h1);
        if (stray_start) begin
            repeat (10) @(negedge clk);
            start_i = 1'b1;  // R6: ignored mid-run
            key_i   = ~key;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(valid_o == 1'b0, "R4", "valid after done", 64'(valid_o), 64'h0);
        check(seen == NSUB, "R3", "subkey count", 64'(seen), 64'(NSUB));
        repeat (5) @(negedge clk);
        check(valid_o == 1'b0, "R6", "no second run", 64'(valid_o), 64'h0);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 64'h0, 64'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && done_o == 1'b0, "R7", "reset state",
              64'({valid_o, done_o}), 64'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0, "R8", "idle without start", 64'(valid_o), 64'h0);

        run_key(128'h0001_0002_0003_0004_0005_0006_0007_0008, 1'b0);
        check(obs[0] == 16'h0001 && obs[7] == 16'h0008, "R1", "direct words",
              64'({obs[0], obs[7]}), 64'h0001_0008);
        check(obs[8] == 16'h0400, "R2", "ninth subkey", 64'(obs[8]), 64'h0400);

        run_key({$urandom, $urandom, $urandom, $urandom}, 1'b1);
        run_key({128{1'b1}}, 1'b0);

        // R7: reset aborts a run.
        q.delete();
        @(negedge clk);
        start_i = 1'b1;
        key_i   = 128'h1234;
        @(negedge clk);
        start_i = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0 && done_o == 1'b0, "R7", "abort by reset",
              64'({valid_o, done_o}), 64'h0);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(valid_o == 1'b0, "R7", "stays idle after reset", 64'(valid_o), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule